// File: doc/BRIEF.md
# Segmented Line Read Requester

This block turns byte-granular read requests into accesses on a wide RAM read port. Each request gives a byte address and a byte count. The port is one line of 1024 bits, split into eight segments of 16 bytes. Each segment has its own enable bit and its own address field. Requests wait in a small in-order queue. The block has only one request outstanding on the RAM port at a time.

When a request reaches the head of the queue, the block decodes it. The low address bits give the offset inside the 128-byte line, and the upper bits give the line number. The block sets the enable bit of every segment that the byte range touches. It copies the line number into all eight segment address fields and raises response-ready in the same cycle. It then holds the access until the RAM returns response-valid. The requested bytes are then cut out of the returned line, packed down to byte 0, and reported with a one-cycle completion pulse.

A request whose range would run past the end of its line is not sent to the RAM. A request of length zero is also not sent. In both cases the block reports completion at once with an error flag.

Top module: `segrd_mem_reader`

## Requirements
- R1: `req_ready` is high whenever the internal queue (default 4 entries) has room. Requests accepted on `req_valid && req_ready` are served strictly in arrival order.
- R2: The cycle after a request becomes the queue head with the block idle, a valid request appears on the RAM port. The head becomes valid one clock after it is accepted into an empty queue.
- R3: `mem_seg_en[j]` is 1 exactly when segment j (bytes 16j to 16j+15 of the line) holds at least one byte between offset = addr[6:0] and offset + len − 1. The enabled segments therefore form one contiguous run.
- R4: Every 12-bit field `mem_seg_addr[12j+11:12j]`, j = 0..7 with segment 0 in the lowest bits, carries the line number addr[18:7].
- R5: `mem_resready` is high exactly while a request is outstanding, together with a non-zero `mem_seg_en`. The port contents stay stable until response-valid arrives, and no second request is issued meanwhile.
- R6: When `mem_resvalid` is seen while `mem_resready` is high, then in the next cycle `cpl_valid` is 1 and `cpl_err` is 0. In that same cycle `mem_seg_en` and `mem_resready` are 0.
- R7: On a successful completion, byte i of `cpl_data` (bits 8i+7:8i) equals byte offset+i of `mem_rdata` for i < len, and is 0 for i ≥ len. `cpl_len` equals the request length.
- R8: A request with len = 0 or len > 128 − offset produces, one cycle after it is taken from the queue, `cpl_valid` = 1 with `cpl_err` = 1 and `cpl_data` = 0. It drives no RAM access.
- R9: `mem_resvalid` with no request outstanding is ignored: no completion follows.
- R10: After reset, `cpl_valid`, `cpl_err`, `mem_seg_en`, `mem_resready` and `mem_seg_addr` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room |
| req_addr | input | 19 | Byte address: line in [18:7], offset in [6:0] |
| req_len | input | 8 | Byte count, 1 to 128 |
| mem_seg_en | output | 8 | Per-segment read enable |
| mem_seg_addr | output | 96 | Line number per segment, 12 bits each |
| mem_resready | output | 1 | Ready for the RAM response |
| mem_resvalid | input | 1 | RAM response present |
| mem_rdata | input | 1024 | Returned line, byte k in bits 8k+7:8k |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_err | output | 1 | Completion is a rejection |
| cpl_len | output | 8 | Length of the completed request |
| cpl_data | output | 1024 | Packed bytes, byte 0 first, zero-filled |

## Verification
The bench counts register stages from the clock edge that accepts a request. The RAM port outputs are due one edge later, because the queue write and the issue register each take one edge. A rejection's completion is also due at that point. A completion is due exactly one edge after the edge at which response-valid meets response-ready. All inputs are driven and all outputs sampled on the falling clock edge, so every check lands in the cycle where the value has just been registered. The fill-and-drain test waits for each issue with a bounded poll, because its issue time depends on the queue state.

// File: rtl/segrd_pkg.sv
package segrd_pkg;

    localparam int LINE_BYTES = 128;
    localparam int SEG_NUM    = 8;
    localparam int SEG_BYTES  = LINE_BYTES / SEG_NUM;
    localparam int LINE_AW    = 12;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int BYTE_AW    = LINE_AW + OFF_W;
    localparam int LEN_W      = OFF_W + 1;
    localparam int DATA_W     = LINE_BYTES * 8;
    localparam int SEGA_W     = SEG_NUM * LINE_AW;

    typedef struct packed {
        logic [BYTE_AW-1:0] addr;
        logic [LEN_W-1:0]   len;
    } rd_req_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } iss_state_e;

    // Range [off, off+len-1] stays inside the line and is not empty
    function automatic logic req_fits(input logic [OFF_W-1:0] off,
                                      input logic [LEN_W-1:0] len);
        return (len != '0) && (int'(len) <= LINE_BYTES - int'(off));
    endfunction

    // Segments touched by the byte range
    function automatic logic [SEG_NUM-1:0] seg_mask(input logic [OFF_W-1:0] off,
                                                    input logic [LEN_W-1:0] len);
        int first_s;
        int last_s;
        logic [SEG_NUM-1:0] m;
        first_s = int'(off) / SEG_BYTES;
        last_s  = (int'(off) + int'(len) - 1) / SEG_BYTES;
        for (int j = 0; j < SEG_NUM; j++) begin
            m[j] = (j >= first_s) && (j <= last_s);
        end
        return m;
    endfunction

endpackage

// File: rtl/segrd_req_fifo.sv
module segrd_req_fifo
    import segrd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  rd_req_t din,
    output logic    full,
    input  logic    pop,
    output rd_req_t dout,
    output logic    empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rd_req_t        store [DEPTH];
    logic [PW-1:0]  wr_ptr;
    logic [PW-1:0]  rd_ptr;
    logic [CW-1:0]  count;
    logic           do_push;
    logic           do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_ptr];

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/segrd_line_map.sv
module segrd_line_map
    import segrd_pkg::*;
(
    input  rd_req_t            req,
    output logic               fits,
    output logic [OFF_W-1:0]   off,
    output logic [SEG_NUM-1:0] mask,
    output logic [SEGA_W-1:0]  seg_addr
);
    logic [LINE_AW-1:0] line_no;

    assign line_no = req.addr[BYTE_AW-1:OFF_W];
    assign off     = req.addr[OFF_W-1:0];
    assign fits    = req_fits(off, req.len);
    assign mask    = fits ? seg_mask(off, req.len) : '0;

    for (genvar g = 0; g < SEG_NUM; g++) begin : g_repl
        assign seg_addr[g*LINE_AW +: LINE_AW] = line_no;
    end

endmodule

// File: rtl/segrd_byte_gather.sv
module segrd_byte_gather
    import segrd_pkg::*;
(
    input  logic [DATA_W-1:0] line_data,
    input  logic [OFF_W-1:0]  off,
    input  logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] packed_data
);
    logic [DATA_W-1:0] shifted;

    assign shifted = line_data >> {off, 3'b000};

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_keep
        assign packed_data[b*8 +: 8] = (LEN_W'(b) < len) ? shifted[b*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/segrd_mem_reader.sv
module segrd_mem_reader
    import segrd_pkg::*;
#(
    parameter int Q_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [BYTE_AW-1:0]   req_addr,
    input  logic [LEN_W-1:0]     req_len,
    output logic [SEG_NUM-1:0]   mem_seg_en,
    output logic [SEGA_W-1:0]    mem_seg_addr,
    output logic                 mem_resready,
    input  logic                 mem_resvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 cpl_valid,
    output logic                 cpl_err,
    output logic [LEN_W-1:0]     cpl_len,
    output logic [DATA_W-1:0]    cpl_data
);
    iss_state_e          state;
    rd_req_t             in_req;
    rd_req_t             head;
    logic                q_full;
    logic                q_empty;
    logic                q_pop;
    logic                head_fits;
    logic [OFF_W-1:0]    head_off;
    logic [SEG_NUM-1:0]  head_mask;
    logic [SEGA_W-1:0]   head_seg_addr;
    logic [OFF_W-1:0]    cur_off;
    logic [LEN_W-1:0]    cur_len;
    logic [DATA_W-1:0]   gathered;

    assign in_req.addr = req_addr;
    assign in_req.len  = req_len;
    assign req_ready   = !q_full;
    assign q_pop       = (state == ST_IDLE) && !q_empty;

    segrd_req_fifo #(.DEPTH(Q_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (req_valid),
        .din   (in_req),
        .full  (q_full),
        .pop   (q_pop),
        .dout  (head),
        .empty (q_empty)
    );

    segrd_line_map u_map (
        .req      (head),
        .fits     (head_fits),
        .off      (head_off),
        .mask     (head_mask),
        .seg_addr (head_seg_addr)
    );

    segrd_byte_gather u_gather (
        .line_data   (mem_rdata),
        .off         (cur_off),
        .len         (cur_len),
        .packed_data (gathered)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            mem_seg_en   <= '0;
            mem_seg_addr <= '0;
            mem_resready <= 1'b0;
            cur_off      <= '0;
            cur_len      <= '0;
            cpl_valid    <= 1'b0;
            cpl_err      <= 1'b0;
            cpl_len      <= '0;
            cpl_data     <= '0;
        end else begin
            cpl_valid <= 1'b0;
            cpl_err   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (q_pop) begin
                        if (head_fits) begin
                            mem_seg_en   <= head_mask;
                            mem_seg_addr <= head_seg_addr;
                            mem_resready <= 1'b1;
                            cur_off      <= head_off;
                            cur_len      <= head.len;
                            state        <= ST_WAIT;
                        end else begin
                            cpl_valid <= 1'b1;
                            cpl_err   <= 1'b1;
                            cpl_len   <= head.len;
                            cpl_data  <= '0;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_resvalid) begin
                        cpl_valid    <= 1'b1;
                        cpl_len      <= cur_len;
                        cpl_data     <= gathered;
                        mem_seg_en   <= '0;
                        mem_seg_addr <= '0;
                        mem_resready <= 1'b0;
                        state        <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/segrd_mem_reader_chk.sv
module segrd_mem_reader_chk
    import segrd_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [BYTE_AW-1:0]   req_addr,
    input logic [LEN_W-1:0]     req_len,
    input logic [SEG_NUM-1:0]   mem_seg_en,
    input logic [SEGA_W-1:0]    mem_seg_addr,
    input logic                 mem_resready,
    input logic                 mem_resvalid,
    input logic [DATA_W-1:0]    mem_rdata,
    input logic                 cpl_valid,
    input logic                 cpl_err,
    input logic [LEN_W-1:0]     cpl_len,
    input logic [DATA_W-1:0]    cpl_data
);
    logic [SEG_NUM-1:0] field_same;
    logic               repl_ok;
    logic [SEG_NUM-1:0] low_bit;
    logic               run_ok;

    for (genvar g = 0; g < SEG_NUM; g++) begin : g_cmp
        assign field_same[g] = (mem_seg_addr[g*LINE_AW +: LINE_AW] == mem_seg_addr[LINE_AW-1:0]);
    end
    assign repl_ok = &field_same;
    assign low_bit = mem_seg_en & (~mem_seg_en + SEG_NUM'(1));
    assign run_ok  = ((mem_seg_en + low_bit) & mem_seg_en) == '0;

    AST_READY_MATCHES_EN: assert property (@(posedge clk) disable iff (rst)
        mem_resready == (mem_seg_en != '0)); // R5

    AST_HOLD_UNTIL_RESP: assert property (@(posedge clk) disable iff (rst)
        (mem_resready && !mem_resvalid) |=> (mem_resready && $stable(mem_seg_en) && $stable(mem_seg_addr))); // R5

    AST_DROP_AFTER_RESP: assert property (@(posedge clk) disable iff (rst)
        (mem_resready && mem_resvalid) |=> (cpl_valid && !cpl_err && !mem_resready && mem_seg_en == '0)); // R6

    AST_ADDR_REPLICATED: assert property (@(posedge clk) disable iff (rst)
        mem_resready |-> repl_ok); // R4

    AST_EN_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
        run_ok); // R3

    AST_REJECT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        cpl_err |-> (cpl_valid && mem_seg_en == '0 && cpl_data == '0)); // R8

    AST_NO_STRAY_CPL: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !cpl_err) |-> $past(mem_resready && mem_resvalid)); // R9

endmodule

bind segrd_mem_reader segrd_mem_reader_chk u_chk (.*);

// File: tb/segrd_mem_reader_tb.sv
module segrd_mem_reader_tb;
    import segrd_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [BYTE_AW-1:0]   req_addr = '0;
    logic [LEN_W-1:0]     req_len = '0;
    logic [SEG_NUM-1:0]   mem_seg_en;
    logic [SEGA_W-1:0]    mem_seg_addr;
    logic                 mem_resready;
    logic                 mem_resvalid = 1'b0;
    logic [DATA_W-1:0]    mem_rdata = '0;
    logic                 cpl_valid;
    logic                 cpl_err;
    logic [LEN_W-1:0]     cpl_len;
    logic [DATA_W-1:0]    cpl_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    segrd_mem_reader u_dut (.*);

    localparam int NV = 8;
    localparam logic [11:0] V_LINE [NV] = '{12'h000, 12'h001, 12'hABC, 12'h3F0, 12'hFFF, 12'h155, 12'h0A0, 12'h777};
    localparam logic [6:0]  V_OFF  [NV] = '{7'd0,    7'd5,    7'd112,  7'd15,   7'd127,  7'd1,    7'd64,   7'd100};
    localparam logic [7:0]  V_LEN  [NV] = '{8'd128,  8'd10,   8'd16,   8'd2,    8'd1,    8'd127,  8'd64,   8'd28};

    task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [SEG_NUM-1:0] exp_mask(input int off, input int len);
        logic [SEG_NUM-1:0] m;
        for (int j = 0; j < SEG_NUM; j++) begin
            m[j] = (off <= 16*j + 15) && (off + len - 1 >= 16*j);
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] make_line(input int seed);
        logic [DATA_W-1:0] d;
        for (int k = 0; k < LINE_BYTES; k++) begin
            d[k*8 +: 8] = 8'((k * 7 + seed * 13 + 1) & 255);
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] exp_pack(input logic [DATA_W-1:0] d, input int off, input int len);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < len; i++) begin
            r[i*8 +: 8] = d[(off + i)*8 +: 8];
        end
        return r;
    endfunction

    task automatic drive_req(input logic [11:0] ln, input logic [6:0] of, input logic [7:0] lg);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {ln, of};
        req_len   = lg;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_fields(input string tag, input logic [11:0] ln);
        for (int j = 0; j < SEG_NUM; j++) begin
            chk(tag, DATA_W'(mem_seg_addr[j*12 +: 12]), DATA_W'(ln));
        end
    endtask

    task automatic respond_and_check(input logic [DATA_W-1:0] d, input int of, input int lg);
        mem_resvalid = 1'b1;
        mem_rdata    = d;
        @(negedge clk);
        mem_resvalid = 1'b0;
        chk("R6 cpl_valid", DATA_W'(cpl_valid), DATA_W'(1));
        chk("R6 cpl_err", DATA_W'(cpl_err), DATA_W'(0));
        chk("R6 seg_en dropped", DATA_W'(mem_seg_en), DATA_W'(0));
        chk("R6 resready dropped", DATA_W'(mem_resready), DATA_W'(0));
        chk("R7 cpl_data", cpl_data, exp_pack(d, of, lg));
        chk("R7 cpl_len", DATA_W'(cpl_len), DATA_W'(lg));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 cpl_valid", DATA_W'(cpl_valid), DATA_W'(0));
        chk("R10 cpl_err", DATA_W'(cpl_err), DATA_W'(0));
        chk("R10 seg_en", DATA_W'(mem_seg_en), DATA_W'(0));
        chk("R10 resready", DATA_W'(mem_resready), DATA_W'(0));
        chk("R10 seg_addr", DATA_W'(mem_seg_addr), DATA_W'(0));
        chk("R10 req_ready", DATA_W'(req_ready), DATA_W'(1));

        // Vector table: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            logic [DATA_W-1:0] d;
            d = make_line(v);
            drive_req(V_LINE[v], V_OFF[v], V_LEN[v]);
            @(negedge clk);
            chk("R2 issued", DATA_W'(mem_resready), DATA_W'(1));
            chk("R3 seg_en", DATA_W'(mem_seg_en), DATA_W'(exp_mask(int'(V_OFF[v]), int'(V_LEN[v]))));
            check_fields("R4 seg_addr", V_LINE[v]);
            @(negedge clk);
            chk("R5 held resready", DATA_W'(mem_resready), DATA_W'(1));
            chk("R5 no early cpl", DATA_W'(cpl_valid), DATA_W'(0));
            respond_and_check(d, int'(V_OFF[v]), int'(V_LEN[v]));
            @(negedge clk);
            chk("R6 cpl pulse ends", DATA_W'(cpl_valid), DATA_W'(0));
        end

        // R8 crossing the line end
        drive_req(12'h010, 7'd100, 8'd29);
        @(negedge clk);
        chk("R8 cpl_valid", DATA_W'(cpl_valid), DATA_W'(1));
        chk("R8 cpl_err", DATA_W'(cpl_err), DATA_W'(1));
        chk("R8 no access", DATA_W'(mem_seg_en), DATA_W'(0));
        chk("R8 no resready", DATA_W'(mem_resready), DATA_W'(0));
        chk("R8 cpl_data zero", cpl_data, '0);
        // R8 zero length
        drive_req(12'h011, 7'd3, 8'd0);
        @(negedge clk);
        chk("R8 len0 err", DATA_W'(cpl_err), DATA_W'(1));
        chk("R8 len0 no access", DATA_W'(mem_resready), DATA_W'(0));

        // R9 stray response
        @(negedge clk);
        mem_resvalid = 1'b1;
        mem_rdata    = make_line(40);
        @(negedge clk);
        mem_resvalid = 1'b0;
        chk("R9 stray ignored", DATA_W'(cpl_valid), DATA_W'(0));
        @(negedge clk);
        chk("R9 stray no cpl later", DATA_W'(cpl_valid), DATA_W'(0));

        // R1 fill the queue while one read is outstanding, then drain in order
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_addr  = {12'(12'h100 + k), 7'd4};
            req_len   = 8'(k + 1);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 full ready low", DATA_W'(req_ready), DATA_W'(0));
        for (int k = 0; k < 5; k++) begin
            int waited;
            waited = 0;
            while (!mem_resready && waited < 10) begin
                @(negedge clk);
                waited++;
            end
            chk("R1 order line", DATA_W'(mem_seg_addr[11:0]), DATA_W'(12'h100 + k));
            respond_and_check(make_line(50 + k), 4, k + 1);
        end
        @(negedge clk);
        chk("R1 ready again", DATA_W'(req_ready), DATA_W'(1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule